// File: doc/BRIEF.md
# In-Place Integer Twin Butterfly

This block performs the core step of FFT and DCT inner loops on signed fixed-point integers. Each operation takes two data words and a coefficient. It forms one product of the second data word and the coefficient, then scales that product down by a per-operation right shift with round-half-up. From the scaled term it forms a sum and a difference against the first data word. Both results go back in place of the two data operands. The sum is steered to the register index of the first operand and the difference to the index of the second, so the caller needs no extra destination registers.

The unit has two stages. The first stage multiplies and scales. The second stage adds and subtracts. It takes one operation per cycle under a valid/ready handshake on each side. The two register indices and a write-back enable for each destination travel down the pipeline with the data. Loop scheduling, twiddle generation and register storage are outside the block.

Top module: `bfly_top`

## Requirements
- R1: When an operation is presented, `out_sum` equals `in_a + T` modulo 2^32. T is the low 32 bits of `(in_b * in_coef + H) >>> in_shift`, where the product is the full 64-bit signed product and H is 2^(in_shift-1) when in_shift > 0, and 0 otherwise. Exactly one product is formed per operation.
- R2: `out_diff` equals `in_a - T` modulo 2^32, using the same T as the sum.
- R3: The scaling rounds half up. For a product of -3 with shift 1 the term is -1; for 3 with shift 1 it is 2; for -1 with shift 1 it is 0. A shift of 0 uses the product unrounded.
- R4: The sum and the difference wrap modulo 2^32 with no saturation. For example, 0x7FFFFFFF + 1 gives 0x80000000.
- R5: `out_idx_sum` carries the `in_idx_a` of the same operation, and `out_idx_diff` carries its `in_idx_b`.
- R6: `out_we_sum` is 1 only while `out_valid` is 1 and the operation's `in_we_a` was 1. `out_we_diff` follows the same rule with `in_we_b`. Both are 0 while `out_valid` is 0.
- R7: An operation is accepted at a rising edge where `in_valid` and `in_ready` are both 1. On an empty pipeline it appears on the outputs after the next rising edge. With `out_ready` held at 1, the unit accepts one operation every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values into the next cycle.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: When both stages hold operations and `out_ready` is 0, `in_ready` is 0. Results leave in the order the operations were accepted, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_a | input | 32 | First data operand, signed |
| in_b | input | 32 | Second data operand, signed |
| in_coef | input | 32 | Coefficient, signed |
| in_shift | input | 5 | Right shift applied to the product |
| in_idx_a | input | 5 | Register index of the first operand |
| in_idx_b | input | 5 | Register index of the second operand |
| in_we_a | input | 1 | Write back the sum |
| in_we_b | input | 1 | Write back the difference |
| out_valid | output | 1 | Result pair present |
| out_ready | input | 1 | Consumer takes the result pair |
| out_sum | output | 32 | a + scaled product |
| out_diff | output | 32 | a - scaled product |
| out_idx_sum | output | 5 | Destination of the sum |
| out_idx_diff | output | 5 | Destination of the difference |
| out_we_sum | output | 1 | Write enable for the sum |
| out_we_diff | output | 1 | Write enable for the difference |

## Verification
The bench targets rounding at negative halves and at the largest shift. A design that truncated, or rounded away from zero, would be off by one on the -3 and -1 cases. The bench also drives sums past the signed limit, which a saturating design would clamp instead of wrapping. Random backpressure with both stages full tests whether a stalled result changes, drops or duplicates; swapped index or enable steering shows up as a wrong destination on the first operation with distinct indices.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int BF_DW = 32;
    localparam int BF_IW = 5;
    localparam int BF_SW = $clog2(BF_DW);
    localparam int BF_PW = 2 * BF_DW;

    typedef logic [BF_DW-1:0] word_t;
    typedef logic [BF_IW-1:0] idx_t;
    typedef logic [BF_SW-1:0] shamt_t;

    // stage 1: operand a, scaled product, steering
    typedef struct packed {
        word_t a;
        word_t scaled;
        idx_t  idx_a;
        idx_t  idx_b;
        logic  we_a;
        logic  we_b;
    } stage1_t;

    // stage 2: results ready for write-back
    typedef struct packed {
        word_t sum;
        word_t diff;
        idx_t  idx_sum;
        idx_t  idx_diff;
        logic  we_sum;
        logic  we_diff;
    } stage2_t;

    function automatic logic [BF_PW-1:0] half_lsb(input shamt_t sh);
        logic [BF_PW-1:0] one;
        one = {{(BF_PW-1){1'b0}}, 1'b1};
        if (sh == '0) return '0;
        return one << (sh - 1'b1);
    endfunction
endpackage

// File: rtl/bfly_mul_scale.sv
module bfly_mul_scale
    import bfly_pkg::*;
(
    input  word_t  b,
    input  word_t  coef,
    input  shamt_t sh,
    output word_t  scaled
);
    logic [BF_PW-1:0]        prod;
    logic signed [BF_PW-1:0] biased;
    logic signed [BF_PW-1:0] shifted;

    // low 2W bits of the extended product equal the signed product
    always_comb begin
        prod    = {{BF_DW{b[BF_DW-1]}}, b} * {{BF_DW{coef[BF_DW-1]}}, coef};
        biased  = $signed(prod + half_lsb(sh));
        shifted = biased >>> sh;
        scaled  = shifted[BF_DW-1:0];
    end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
(
    input  word_t a,
    input  word_t t,
    output word_t sum,
    output word_t diff
);
    // modular arithmetic, no saturation
    always_comb begin
        sum  = a + t;
        diff = a - t;
    end
endmodule

// File: rtl/bfly_top.sv
module bfly_top
    import bfly_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BF_DW-1:0]   in_a,
    input  logic [BF_DW-1:0]   in_b,
    input  logic [BF_DW-1:0]   in_coef,
    input  logic [BF_SW-1:0]   in_shift,
    input  logic [BF_IW-1:0]   in_idx_a,
    input  logic [BF_IW-1:0]   in_idx_b,
    input  logic               in_we_a,
    input  logic               in_we_b,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BF_DW-1:0]   out_sum,
    output logic [BF_DW-1:0]   out_diff,
    output logic [BF_IW-1:0]   out_idx_sum,
    output logic [BF_IW-1:0]   out_idx_diff,
    output logic               out_we_sum,
    output logic               out_we_diff
);
    stage1_t s1_q, s1_d;
    stage2_t s2_q, s2_d;
    logic    v1_q, v2_q;
    logic    adv1, adv2;
    word_t   scaled_w, sum_w, diff_w;

    bfly_mul_scale u_mul (
        .b      (in_b),
        .coef   (in_coef),
        .sh     (in_shift),
        .scaled (scaled_w)
    );

    bfly_addsub u_as (
        .a    (s1_q.a),
        .t    (s1_q.scaled),
        .sum  (sum_w),
        .diff (diff_w)
    );

    assign adv2     = !v2_q || out_ready;
    assign adv1     = !v1_q || adv2;
    assign in_ready = adv1;

    always_comb begin
        s1_d.a      = in_a;
        s1_d.scaled = scaled_w;
        s1_d.idx_a  = in_idx_a;
        s1_d.idx_b  = in_idx_b;
        s1_d.we_a   = in_we_a;
        s1_d.we_b   = in_we_b;

        s2_d.sum      = sum_w;
        s2_d.diff     = diff_w;
        s2_d.idx_sum  = s1_q.idx_a;
        s2_d.idx_diff = s1_q.idx_b;
        s2_d.we_sum   = s1_q.we_a;
        s2_d.we_diff  = s1_q.we_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            if (adv1) begin
                v1_q <= in_valid;
                s1_q <= s1_d;
            end
            if (adv2) begin
                v2_q <= v1_q;
                s2_q <= s2_d;
            end
        end
    end

    assign out_valid    = v2_q;
    assign out_sum      = s2_q.sum;
    assign out_diff     = s2_q.diff;
    assign out_idx_sum  = s2_q.idx_sum;
    assign out_idx_diff = s2_q.idx_diff;
    assign out_we_sum   = v2_q && s2_q.we_sum;
    assign out_we_diff  = v2_q && s2_q.we_diff;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_diff)
            && $stable(out_idx_sum) && $stable(out_idx_diff))); // R8

    AST_NO_WB_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_we_sum && !out_we_diff)); // R6

    AST_SUM_DIFF_GAP: assert property (@(posedge clk) disable iff (rst)
        (v1_q && adv2) |=> (out_valid
            && ((out_sum - out_diff) == ($past(s1_q.scaled) << 1)))); // R2

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && v1_q) |-> !in_ready); // R10

    AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> v1_q); // R7
endmodule

// File: tb/bfly_top_bench.sv
module bfly_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [31:0] in_a, in_b, in_coef;
    logic [4:0]  in_shift, in_idx_a, in_idx_b;
    logic        in_we_a, in_we_b;
    logic        out_valid, out_ready;
    logic [31:0] out_sum, out_diff;
    logic [4:0]  out_idx_sum, out_idx_diff;
    logic        out_we_sum, out_we_diff;

    typedef struct {
        logic [31:0] sum;
        logic [31:0] diff;
        logic [4:0]  isum;
        logic [4:0]  idiff;
        logic        wsum;
        logic        wdiff;
    } exp_t;

    exp_t exq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    logic stall_prev = 1'b0;
    logic [31:0] hold_sum, hold_diff;
    logic [4:0]  hold_is, hold_id;

    always #5 clk = ~clk;

    bfly_top u_bfly_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_shift(in_shift),
        .in_idx_a(in_idx_a), .in_idx_b(in_idx_b), .in_we_a(in_we_a), .in_we_b(in_we_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_diff(out_diff),
        .out_idx_sum(out_idx_sum), .out_idx_diff(out_idx_diff),
        .out_we_sum(out_we_sum), .out_we_diff(out_we_diff)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural scaled term: R1 R3
    function automatic logic [31:0] ref_term(input logic [31:0] b, input logic [31:0] c, input int s);
        longint p;
        p = longint'($signed(b)) * longint'($signed(c));
        if (s > 0) p = p + (longint'(1) << (s - 1));
        p = p >>> s;
        return p[31:0];
    endfunction

    // settle, compare, record handshakes, advance to next negedge
    task automatic tick();
        exp_t e;
        #1;
        if (stall_prev) begin
            chk(out_valid == 1'b1, "R8 valid held", 64'(out_valid), 64'd1);
            chk(out_sum == hold_sum && out_diff == hold_diff, "R8 data held",
                {out_sum, out_diff}, {hold_sum, hold_diff});
            chk(out_idx_sum == hold_is && out_idx_diff == hold_id, "R8 idx held",
                64'({out_idx_sum, out_idx_diff}), 64'({hold_is, hold_id}));
        end
        if (out_valid) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R10 unexpected result", 64'd1, 64'd0);
            end else begin
                e = exq[0];
                chk(out_sum == e.sum, "R1 sum", 64'(out_sum), 64'(e.sum));
                chk(out_diff == e.diff, "R2 diff", 64'(out_diff), 64'(e.diff));
                chk(out_idx_sum == e.isum && out_idx_diff == e.idiff, "R5 indices",
                    64'({out_idx_sum, out_idx_diff}), 64'({e.isum, e.idiff}));
                chk(out_we_sum == e.wsum && out_we_diff == e.wdiff, "R6 enables",
                    64'({out_we_sum, out_we_diff}), 64'({e.wsum, e.wdiff}));
                if (out_ready) void'(exq.pop_front());
            end
        end else begin
            chk(!out_we_sum && !out_we_diff, "R6 idle enables",
                64'({out_we_sum, out_we_diff}), 64'd0);
        end
        stall_prev = out_valid && !out_ready;
        hold_sum = out_sum; hold_diff = out_diff;
        hold_is = out_idx_sum; hold_id = out_idx_diff;
        if (in_valid && in_ready) begin
            e.sum   = in_a + ref_term(in_b, in_coef, int'(in_shift));
            e.diff  = in_a - ref_term(in_b, in_coef, int'(in_shift));
            e.isum  = in_idx_a;
            e.idiff = in_idx_b;
            e.wsum  = in_we_a;
            e.wdiff = in_we_b;
            exq.push_back(e);
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic [4:0] s, input logic [4:0] ia, input logic [4:0] ib,
                         input logic wa, input logic wb);
        in_valid = 1'b1;
        in_a = a; in_b = b; in_coef = c; in_shift = s;
        in_idx_a = ia; in_idx_b = ib; in_we_a = wa; in_we_b = wb;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 20 && (exq.size() != 0 || out_valid); k++) tick();
        chk(exq.size() == 0, "R10 all results delivered", 64'(exq.size()), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        out_ready = 1'b1;
        drive('0, '0, '0, '0, '0, '0, 1'b0, 1'b0);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'd1);
        @(negedge clk);

        // directed: plain product, rounding cases (R3), wrap (R4), max shift
        drive(32'd100, 32'd7, 32'd3, 5'd0, 5'd1, 5'd2, 1'b1, 1'b1); tick();
        chk(ref_term(32'hFFFF_FFFD, 32'd1, 1) == 32'hFFFF_FFFF, "R3 model -3>>1", 64'd0, 64'd0);
        drive(32'd0, -32'sd3, 32'd1, 5'd1, 5'd3, 5'd4, 1'b1, 1'b0); tick();
        drive(32'd0, 32'd3, 32'd1, 5'd1, 5'd5, 5'd6, 1'b0, 1'b1); tick();
        drive(32'd10, -32'sd1, 32'd1, 5'd1, 5'd7, 5'd8, 1'b1, 1'b1); tick();
        drive(32'h7FFF_FFFF, 32'd1, 32'd1, 5'd0, 5'd9, 5'd10, 1'b1, 1'b1); tick();
        drive(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 5'd31, 5'd31, 5'd0, 1'b1, 1'b1); tick();
        drive(32'h8000_0000, 32'd1, 32'd1, 5'd0, 5'd12, 5'd13, 1'b1, 1'b1); tick();
        drain();

        // R3: direct checks of rounding through the ports
        drive(32'd0, -32'sd3, 32'd1, 5'd1, 5'd1, 5'd2, 1'b1, 1'b1); tick();
        in_valid = 1'b0; tick();
        #1;
        chk(out_valid && out_sum == 32'hFFFF_FFFF, "R3 -3 shift1 gives -1", 64'(out_sum), 64'hFFFF_FFFF);
        tick(); drain();

        // R7 latency on empty pipeline
        drive(32'd5, 32'd2, 32'd2, 5'd0, 5'd3, 5'd4, 1'b1, 1'b1);
        tick();
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R7 not early", 64'(out_valid), 64'd0);
        tick();
        #1;
        chk(out_valid == 1'b1 && out_sum == 32'd9, "R7 after next edge", 64'(out_sum), 64'd9);
        tick(); drain();

        // R10 fill both stages under backpressure
        out_ready = 1'b0;
        for (int k = 0; k < 4; k++) begin
            drive(32'(k * 11), 32'(k + 1), 32'd4, 5'd1, 5'(k), 5'(k + 8), 1'b1, 1'b0);
            tick();
        end
        #1;
        chk(in_ready == 1'b0, "R10 full and stalled", 64'(in_ready), 64'd0);
        drain();

        // R7 throughput: back-to-back with out_ready high
        out_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            drive(32'(k), 32'(k * 3), 32'hFFFF_FFF0, 5'(k), 5'(k), 5'(31 - k), 1'b1, 1'b1);
            #1;
            chk(in_ready == 1'b1, "R7 one per cycle", 64'(in_ready), 64'd1);
            tick();
        end
        drain();

        // random traffic with random backpressure
        for (int k = 0; k < 3000; k++) begin
            drive($urandom, $urandom, $urandom, 5'($urandom_range(0, 31)),
                  5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
            in_valid = ($urandom_range(0, 9) < 7);
            out_ready = ($urandom_range(0, 9) < 6);
            tick();
        end
        drain();

        report();
        $finish;
    end
endmodule